// File: doc/BRIEF.md
# SONET/SDH Frame Synchronizer

The block sits after a byte-wide deserializer. The deserializer's words carry no byte alignment, so each 8-bit word may start at any bit of the line. On every receive clock the block forms a 16-bit window from the previous word and the current word. It looks at all eight bit offsets of that window for the SONET/SDH framing run: three A1 bytes, then one A2 byte.

When a run is found while searching is enabled, the block takes that bit offset as a candidate. It then checks that the same run comes back exactly one frame period later, twice more. After the third run at the right spacing, the block declares lock, marks its realigned output bytes as valid and gives a short frame-sync pulse.

Once locked, a framing run that appears anywhere other than the expected frame position is ignored. Lock is dropped only after a series of missing runs at the expected position. Deasserting the enable input freezes the chosen offset and the locked state.

Top module: `frame_aligner`

## Requirements
- R1: A match is the bytes F6h, F6h, F6h, then 28h, back to back at one bit offset, with bits taken MSB first. All eight bit offsets of the {previous word, current word} window are searched. A run with only two F6h bytes before 28h is not a match.
- R2: The block starts an acquisition only while `frame_en` is high. With `frame_en` held low from reset, valid framing never leads to lock.
- R3: While locked with `frame_en` low, the offset, the lock and the output alignment are held, and missing framing runs are not counted. Counting resumes when `frame_en` returns high.
- R4: `byte_valid` is low whenever the block is not locked, which covers hunting and confirming.
- R5: Lock is declared on the third run found at exactly FRAME_LEN clocks after the previous one. If a run is missing at the expected position while confirming, the block returns to hunting, and a later run starts a new count.
- R6: On lock, `frame_sync` is high for exactly PULSE_LEN (default 4) clocks. The pulse starts in the same cycle that `byte_valid` rises, which is one clock after the cycle in which the confirming 28h byte is seen.
- R7: While locked, a framing run at any position other than the expected frame position changes neither the offset nor the lock.
- R8: While locked and enabled, lock is lost only after LOSS_FRAMES (default 4) consecutive expected positions without a match. Fewer consecutive misses keep the lock.
- R9: `rx_byte` is the byte at the chosen offset, one register stage after the cycle in which it is complete in the window. The first valid byte is the confirming 28h.
- R10: A synchronous active-high `rst` clears the offset to 0 and drives `byte_valid`, `frame_sync` and `rx_byte` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive byte clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_en | input | 1 | Allows searching and lock-loss counting |
| rx_word | input | 8 | Unaligned word from the deserializer |
| rx_byte | output | 8 | Realigned byte |
| byte_valid | output | 1 | High while locked |
| frame_sync | output | 1 | Pulse on declaring lock |

## Verification
A wrong stored offset shows on `rx_byte` in the first locked cycle, because the first valid byte must be 28h and each later byte must follow the stream. A frame counter that is off by one shows as lock declared in the wrong cycle, or as no lock at all. Both are visible within three frame periods of the first framing run. A miss counter or enable-freeze fault shows as `byte_valid` falling at the wrong expected position, or not falling at all. The bench checks every cycle of every frame in each scenario, across all eight bit offsets.

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int FRAME_LEN      = 2430,
  parameter int CONFIRM_FRAMES = 3,
  parameter int LOSS_FRAMES    = 4,
  parameter int PULSE_LEN      = 4,
  parameter logic [7:0] A1_BYTE = 8'hF6,
  parameter logic [7:0] A2_BYTE = 8'h28
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_en,
  input  logic [7:0] rx_word,
  output logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic       frame_sync
);

  localparam int PW = $clog2(FRAME_LEN);
  localparam int CW = $clog2(CONFIRM_FRAMES + 1);
  localparam int LW = $clog2(LOSS_FRAMES + 1);
  localparam int FW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] POS_LAST  = PW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] SEEN_LAST = CW'(CONFIRM_FRAMES - 1);
  localparam logic [LW-1:0] MISS_LAST = LW'(LOSS_FRAMES - 1);

  typedef enum logic [1:0] {HUNT, CONFIRM, LOCKED} state_t;

  state_t          state_q;
  logic [7:0]      prev_q;
  logic [2:0]      off_q;
  logic [PW-1:0]   pos_q;
  logic [CW-1:0]   seen_q;
  logic [LW-1:0]   miss_q;
  logic [FW-1:0]   pulse_q;
  logic [7:0][1:0] run_q;
  logic [7:0][7:0] lane;
  logic [7:0]      hit;
  logic [15:0]     win;
  logic [2:0]      first_off;
  logic            at_edge;
  logic            exp_hit;

  assign win = {prev_q, rx_word};

  for (genvar k = 0; k < 8; k++) begin : g_lane
    assign lane[k] = win[15-k -: 8];
    assign hit[k]  = (lane[k] == A2_BYTE) && (run_q[k] == 2'd3);
  end

  always_comb begin
    first_off = 3'd0;
    for (int k = 7; k >= 0; k--)
      if (hit[k]) first_off = 3'(k);
  end

  assign at_edge    = (pos_q == '0);
  assign exp_hit    = hit[off_q];
  assign byte_valid = (state_q == LOCKED);
  assign frame_sync = (pulse_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else begin
      for (int k = 0; k < 8; k++) begin
        if (lane[k] == A1_BYTE)
          run_q[k] <= (run_q[k] == 2'd3) ? 2'd3 : run_q[k] + 2'd1;
        else
          run_q[k] <= 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HUNT;
      prev_q  <= '0;
      off_q   <= '0;
      pos_q   <= '0;
      seen_q  <= '0;
      miss_q  <= '0;
      pulse_q <= '0;
      rx_byte <= '0;
    end else begin
      prev_q  <= rx_word;
      rx_byte <= lane[off_q];
      pos_q   <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      case (state_q)
        HUNT: begin
          if (frame_en && (hit != '0)) begin
            off_q   <= first_off;
            pos_q   <= PW'(1);
            seen_q  <= CW'(1);
            state_q <= CONFIRM;
          end
        end
        CONFIRM: begin
          if (!frame_en) begin
            state_q <= HUNT;
          end else if (at_edge) begin
            if (!exp_hit) begin
              state_q <= HUNT;
            end else if (seen_q == SEEN_LAST) begin
              state_q <= LOCKED;
              miss_q  <= '0;
              pulse_q <= FW'(PULSE_LEN);
            end else begin
              seen_q <= seen_q + 1'b1;
            end
          end
        end
        LOCKED: begin
          if (frame_en && at_edge) begin
            if (exp_hit) miss_q <= '0;
            else if (miss_q == MISS_LAST) state_q <= HUNT;
            else miss_q <= miss_q + 1'b1;
          end
        end
        default: state_q <= HUNT;
      endcase
    end
  end

endmodule

// File: rtl/frame_aligner_chk.sv
module frame_aligner_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       frame_en,
  input logic       byte_valid,
  input logic       frame_sync,
  input logic [7:0] rx_byte,
  input logic [2:0] off_q,
  input logic       at_edge
);

  int hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= 0;
    else if (frame_sync) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!byte_valid && !frame_sync && off_q == 3'd0 && rx_byte == 8'd0)); // R10
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst) hi_cnt <= PULSE_LEN); // R6
  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (rst) $fell(frame_sync) |-> hi_cnt == PULSE_LEN); // R6
  AST_SYNC_WITH_VALID: assert property (@(posedge clk) disable iff (rst) $rose(frame_sync) |-> $rose(byte_valid)); // R6
  AST_VALID_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst) $rose(byte_valid) |-> frame_sync); // R4
  AST_LOCK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst) $rose(byte_valid) |-> $past(frame_en)); // R2
  AST_FROZEN_OFFSET: assert property (@(posedge clk) disable iff (rst) !frame_en |=> $stable(off_q)); // R3
  AST_FROZEN_LOCK: assert property (@(posedge clk) disable iff (rst) (byte_valid && !frame_en) |=> byte_valid); // R3
  AST_NO_FALSE_REFRAME: assert property (@(posedge clk) disable iff (rst) (byte_valid && !at_edge) |=> (byte_valid && $stable(off_q))); // R7

endmodule

bind frame_aligner frame_aligner_chk #(.PULSE_LEN(PULSE_LEN)) chk (
  .clk(clk), .rst(rst), .frame_en(frame_en), .byte_valid(byte_valid),
  .frame_sync(frame_sync), .rx_byte(rx_byte), .off_q(off_q), .at_edge(at_edge)
);

// File: tb/frame_aligner_test.sv
module frame_aligner_test;
  localparam int L = 16;
  localparam int P = 4;
  localparam int N = 512;

  logic clk = 0;
  logic rst = 1;
  logic frame_en = 0;
  logic [7:0] din = 0;
  logic [7:0] rx_byte;
  logic byte_valid, frame_sync;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] bs [0:N-1];
  logic en_arr [0:N-1];
  logic obs_v [0:N-1];
  logic obs_f [0:N-1];
  logic [7:0] obs_d [0:N-1];

  frame_aligner #(.FRAME_LEN(L)) uut (
    .clk(clk), .rst(rst), .frame_en(frame_en), .rx_word(din),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .frame_sync(frame_sync)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int j);
    if (j < 3) return 8'hF6;
    if (j == 3) return 8'h28;
    return 8'(j);
  endfunction

  task automatic clear_stream(input int nframes);
    for (int i = 0; i < N; i++) begin bs[i] = 8'h00; en_arr[i] = 1'b1; end
    for (int f = 0; f < nframes; f++)
      for (int j = 0; j < L; j++) bs[P + f*L + j] = fb(j);
  endtask

  function automatic logic [7:0] word(input int m, input int s);
    logic [15:0] t;
    t = {bs[m], bs[m+1]};
    t = t << s;
    return t[15:8];
  endfunction

  task automatic run(input int s, input int n);
    rst = 1; frame_en = 0; din = 0;
    repeat (2) @(posedge clk);
    #1;
    check(!byte_valid && !frame_sync && rx_byte == 8'd0, "R10", "reset outputs",
          {byte_valid, frame_sync, rx_byte}, 0);
    rst = 0;
    for (int m = 0; m < n; m++) begin
      din = word(m, s);
      frame_en = en_arr[m];
      @(posedge clk);
      #1;
      obs_v[m] = byte_valid; obs_f[m] = frame_sync; obs_d[m] = rx_byte;
    end
  endtask

  task automatic expect_lock(input int t, input string req);
    int c = 0;
    check(obs_v[t-1] == 0, req, "valid before lock", obs_v[t-1], 0);
    check(obs_v[t] == 1, req, "valid at lock", obs_v[t], 1);
    for (int i = 0; i < 4; i++) c += obs_f[t+i];
    check(c == 4 && obs_f[t-1] == 0 && obs_f[t+4] == 0, "R6", "sync pulse width", c, 4);
    check(obs_d[t] == 8'h28, "R9", "first valid byte", obs_d[t], 8'h28);
  endtask

  task automatic expect_data(input int a, input int b, input int z, input string req);
    int bad = 0;
    for (int m = a; m < b; m++)
      if (obs_v[m] && obs_d[m] != bs[m-z]) bad++;
    check(bad == 0, req, "byte alignment mismatches", bad, 0);
  endtask

  task automatic count_valid(input int a, input int b, input int exp, input string req);
    int c = 0;
    for (int m = a; m < b; m++) c += obs_v[m];
    check(c == exp, req, "valid cycles", c, exp);
  endtask

  task automatic count_sync(input int n, input int exp, input string req);
    int c = 0;
    for (int m = 0; m < n; m++) c += obs_f[m];
    check(c == exp, req, "sync cycles", c, exp);
  endtask

  initial begin
    int n, t, z, x;
    // R1 R4 R5 R6 R9: lock on every bit offset
    for (int s = 0; s < 8; s++) begin
      z = (s == 0);
      n = P + 5*L + 2;
      clear_stream(5);
      run(s, n);
      t = P + 2*L + 3 + z;
      count_valid(0, t, 0, "R4");
      expect_lock(t, "R1");
      count_valid(t, n, n - t, "R5");
      count_sync(n, 4, "R6");
      expect_data(t, n, z, "R9");
    end

    // R1: two A1 bytes only
    n = P + 5*L + 2;
    clear_stream(5);
    for (int f = 0; f < 5; f++) bs[P + f*L] = 8'h00;
    run(2, n);
    count_valid(0, n, 0, "R1");

    // R5: missing second run restarts the count
    n = P + 7*L + 2;
    clear_stream(7);
    bs[P + L + 3] = 8'h00;
    run(6, n);
    t = P + 4*L + 3;
    count_valid(0, t, 0, "R5");
    expect_lock(t, "R5");

    // R7: payload pattern while locked
    n = P + 6*L + 2;
    clear_stream(6);
    for (int f = 3; f < 5; f++) begin
      bs[P + f*L + 7] = 8'hF6; bs[P + f*L + 8] = 8'hF6;
      bs[P + f*L + 9] = 8'hF6; bs[P + f*L + 10] = 8'h28;
    end
    run(1, n);
    t = P + 2*L + 3;
    expect_lock(t, "R7");
    count_valid(t, n, n - t, "R7");
    count_sync(n, 4, "R7");
    expect_data(t, n, 0, "R7");

    // R8: three misses keep lock
    n = P + 8*L + 2;
    clear_stream(8);
    for (int f = 3; f < 6; f++) bs[P + f*L + 3] = 8'h00;
    run(4, n);
    t = P + 2*L + 3;
    count_valid(t, n, n - t, "R8");

    // R8: four misses drop lock, then reacquire
    n = P + 11*L + 2;
    clear_stream(11);
    for (int f = 3; f < 7; f++) bs[P + f*L + 3] = 8'h00;
    run(4, n);
    x = P + 6*L + 3;
    count_valid(t, x, x - t, "R8");
    check(obs_v[x] == 0, "R8", "valid after fourth miss", obs_v[x], 0);
    t = P + 9*L + 3;
    count_valid(x, t, 0, "R4");
    expect_lock(t, "R8");

    // R2: enable held low
    n = P + 5*L + 2;
    clear_stream(5);
    for (int i = 0; i < N; i++) en_arr[i] = 1'b0;
    run(3, n);
    count_valid(0, n, 0, "R2");
    count_sync(n, 0, "R2");

    // R3: freeze while disabled, counting resumes after
    n = P + 14*L + 2;
    clear_stream(14);
    for (int f = 3; f < 13; f++) bs[P + f*L + 3] = 8'h00;
    for (int m = P + 3*L - 2; m < P + 9*L; m++) en_arr[m] = 1'b0;
    run(5, n);
    t = P + 2*L + 3;
    x = P + 12*L + 3;
    expect_lock(t, "R3");
    count_valid(t, x, x - t, "R3");
    check(obs_v[x] == 0, "R3", "valid after resumed misses", obs_v[x], 0);
    expect_data(t, x, 0, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule